// File: doc/BRIEF.md
# Multi-channel down-counting timer unit

This peripheral holds three down-counting channels and one wide up-counter, all running on a single system clock and reached through a word-addressed register bus. Two channels are 16 bits wide and one is 32 bits wide. Each of them counts on one of two tick-enable pulse inputs, a slow one and a fast one. It either reloads from its load register or wraps to all ones when it passes zero. Every pass through zero raises that channel's interrupt, which stays high until software writes the channel's clear register.

The fourth counter is 40 bits wide and counts up on its own tick-enable input. It never interrupts. Software reads it as two words: the low 32 bits, and a high word that holds the top 8 bits together with the run enable. A typical setup programs one channel as a periodic interrupt source and lets the wide counter act as a timestamp for measuring elapsed time between interrupts.

Register map (word addresses): channel c (0, 1, 2) occupies addresses 4c to 4c+3 as load, value (read only), control and clear. Address 12 is the wide counter's low word (read only) and address 13 is its high word. Unmapped addresses read as zero.

Top module: `quad_timer`

## Requirements
- R1: After reset every count, load value, control value and interrupt is zero, and the wide counter is stopped at zero.
- R2: Writing a channel's load register (address 4c) stores the value and sets the channel's count to it on the same clock edge. A write overrides any tick in that cycle.
- R3: While control bit 7 is set, a channel decrements once per pulse of its selected tick. Control bit 3 = 1 selects tick_fast and 0 selects tick_slow, and pulses on the other tick input have no effect.
- R4: With control bit 6 set (periodic), a tick at count zero reloads the count from the load register, so interrupts come every load+1 ticks.
- R5: With control bit 6 clear (free-run), a tick at count zero wraps the count to the channel's all-ones value (0xFFFF or 0xFFFFFFFF).
- R6: A tick at count zero sets the channel's irq bit one cycle later. A write of any data to the channel's clear register (address 4c+3) drops it. If an underflow and a clear fall in the same cycle, the interrupt stays set.
- R7: With control bit 7 clear, the count holds its value whatever the tick inputs do.
- R8: Channels 0 and 1 keep 16 bits: a load is truncated to 16 bits and reads return zeros above bit 15. Channel 2 keeps 32 bits.
- R9: Writing the wide counter's high word (address 13) with bit 8 set starts it, and it then adds one per tick_free pulse. Writing it with bit 8 clear stops it and zeroes it. Address 12 reads bits 31:0. Address 13 reads bits 39:32 in bits 7:0 and the enable in bit 8.
- R10: The wide counter has no effect on the irq outputs.
- R11: The control register reads back bit 7, bit 6 and bit 3 as written, and reads zero in every other bit. Thus 0x48 programs periodic mode with the counter stopped and reads back 0x48, and 0xC8 starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Slow tick enable, single-cycle pulses |
| tick_fast | input | 1 | Fast tick enable, single-cycle pulses |
| tick_free | input | 1 | Tick enable for the wide counter |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 3 | Pending interrupt per channel |

## Verification
The assertions assume that every bus write lasts exactly one cycle and that the tick inputs are synchronous to clk. They also assume that a load write and a tick landing in the same cycle resolve in favour of the write. The random stimulus produces only single-cycle writes at a negative edge. It keeps load values small so that underflows, reloads and wraps happen often. It mixes ticks, clears and control changes freely in the same cycles, so the priority rules are exercised rather than avoided.

// File: rtl/quad_timer.sv
module quad_timer #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic          tick_free,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [2:0]    irq
);
  localparam int NCH = 3;
  localparam logic [AW-1:0] ADDR_FREE_LO = AW'(12);
  localparam logic [AW-1:0] ADDR_FREE_HI = AW'(13);

  logic [31:0] load_q [NCH];
  logic [31:0] cnt_q  [NCH];
  logic [2:0]  ctrl_q [NCH];
  logic [NCH-1:0] uf;
  logic [NCH-1:0] pend_q;
  logic [FREE_W-1:0] free_q;
  logic free_en_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int CW = (i == 2) ? WIDE_W : NARROW_W;
    localparam logic [31:0] MASK = (CW >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << CW) - 64'd1);
    localparam logic [AW-1:0] BASE = AW'(4 * i);

    wire wr_load = bus_we && (bus_addr == BASE);
    wire wr_ctrl = bus_we && (bus_addr == BASE + AW'(2));
    wire wr_clr  = bus_we && (bus_addr == BASE + AW'(3));
    wire tk      = ctrl_q[i][0] ? tick_fast : tick_slow;
    wire step    = ctrl_q[i][2] && tk && !wr_load;

    assign uf[i] = step && (cnt_q[i] == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q[i] <= '0;
        cnt_q[i]  <= '0;
        ctrl_q[i] <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr_load) begin
          load_q[i] <= bus_wdata & MASK;
          cnt_q[i]  <= bus_wdata & MASK;
        end else if (step) begin
          if (cnt_q[i] == 32'd0) cnt_q[i] <= ctrl_q[i][1] ? load_q[i] : MASK;
          else                   cnt_q[i] <= cnt_q[i] - 32'd1;
        end
        if (wr_ctrl) ctrl_q[i] <= {bus_wdata[7], bus_wdata[6], bus_wdata[3]};
        if (uf[i])       pend_q[i] <= 1'b1;
        else if (wr_clr) pend_q[i] <= 1'b0;
      end
    end
  end

  assign irq = pend_q;

  wire wr_free_hi = bus_we && (bus_addr == ADDR_FREE_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q    <= '0;
      free_en_q <= 1'b0;
    end else if (wr_free_hi) begin
      free_en_q <= bus_wdata[8];
      if (!bus_wdata[8]) free_q <= '0;
    end else if (free_en_q && tick_free) begin
      free_q <= free_q + 1'b1;
    end
  end

  logic [1:0] ch_sel;
  assign ch_sel = bus_addr[3:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < ADDR_FREE_LO) begin
      case (bus_addr[1:0])
        2'd0: bus_rdata = load_q[ch_sel];
        2'd1: bus_rdata = cnt_q[ch_sel];
        2'd2: bus_rdata = {24'd0, ctrl_q[ch_sel][2], ctrl_q[ch_sel][1], 2'd0, ctrl_q[ch_sel][0], 3'd0};
        default: bus_rdata = '0;
      endcase
    end else if (bus_addr == ADDR_FREE_LO) begin
      bus_rdata = free_q[31:0];
    end else if (bus_addr == ADDR_FREE_HI) begin
      bus_rdata[8] = free_en_q;
      bus_rdata[FREE_W-33:0] = free_q[FREE_W-1:32];
    end
  end
endmodule

// File: rtl/quad_timer_chk.sv
module quad_timer_chk #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40,
  parameter int AW       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [2:0]        irq,
  input logic [31:0]       load_q [3],
  input logic [31:0]       cnt_q  [3],
  input logic [2:0]        ctrl_q [3],
  input logic [2:0]        uf,
  input logic [FREE_W-1:0] free_q,
  input logic              free_en_q
);
  for (genvar i = 0; i < 3; i++) begin : g_chk
    localparam int CW = (i == 2) ? WIDE_W : NARROW_W;
    localparam logic [31:0] MASK = (CW >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << CW) - 64'd1);
    localparam logic [AW-1:0] BASE = AW'(4 * i);

    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == BASE) |=> (cnt_q[i] == ($past(bus_wdata) & MASK))); // R2
    AST_RELOAD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[i] && ctrl_q[i][1]) |=> (cnt_q[i] == load_q[i])); // R4
    AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[i] && !ctrl_q[i][1]) |=> (cnt_q[i] == MASK)); // R5
    AST_IRQ_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      uf[i] |=> irq[i]); // R6
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == BASE + AW'(3) && !uf[i]) |=> !irq[i]); // R6
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[i][2] && !(bus_we && bus_addr == BASE)) |=> $stable(cnt_q[i])); // R7
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q[i] & ~MASK) == 32'd0)); // R8
  end

  AST_FREE_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_en_q && !(bus_we && bus_addr == AW'(13))) |=> $stable(free_q)); // R9
endmodule

bind quad_timer quad_timer_chk #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .FREE_W(FREE_W), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .load_q(load_q), .cnt_q(cnt_q),
  .ctrl_q(ctrl_q), .uf(uf), .free_q(free_q), .free_en_q(free_en_q)
);

// File: tb/quad_timer_tb_top.sv
module quad_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_slow = 1'b0, tick_fast = 1'b0, tick_free = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .tick_free(tick_free), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  logic [31:0] m_load [3];
  logic [31:0] m_cnt  [3];
  logic [7:0]  m_ctrl [3];
  logic [2:0]  m_pend;
  logic [39:0] m_free;
  logic        m_fen;

  function automatic logic [31:0] mask_of(int c);
    return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    if (a < 4'd12) begin
      case (a[1:0])
        2'd0: return m_load[a[3:2]];
        2'd1: return m_cnt[a[3:2]];
        2'd2: return {24'd0, m_ctrl[a[3:2]]};
        default: return 32'd0;
      endcase
    end
    if (a == 4'd12) return m_free[31:0];
    if (a == 4'd13) return {23'd0, m_fen, m_free[39:32]};
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [3:0] a);
    if (a >= 4'd12) return (a <= 4'd13) ? "R9" : "R8";
    case (a[1:0])
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic model_step(logic we, logic [3:0] a, logic [31:0] d,
                            logic ts, logic tf, logic tfr);
    for (int c = 0; c < 3; c++) begin
      logic tk, stp, ufl;
      tk  = m_ctrl[c][3] ? tf : ts;
      stp = m_ctrl[c][7] && tk && !(we && a == 4'(4*c));
      ufl = stp && (m_cnt[c] == 32'd0);
      if (we && a == 4'(4*c)) begin
        m_load[c] = d & mask_of(c);
        m_cnt[c]  = d & mask_of(c);
      end else if (stp) begin
        m_cnt[c] = (m_cnt[c] == 32'd0) ? (m_ctrl[c][6] ? m_load[c] : mask_of(c)) : m_cnt[c] - 1;
      end
      if (we && a == 4'(4*c+2)) m_ctrl[c] = d[7:0] & 8'hC8;
      if (ufl) m_pend[c] = 1'b1;
      else if (we && a == 4'(4*c+3)) m_pend[c] = 1'b0;
    end
    if (we && a == 4'd13) begin
      m_fen = d[8];
      if (!d[8]) m_free = '0;
    end else if (m_fen && tfr) begin
      m_free = m_free + 1;
    end
  endtask

  task automatic cyc(logic we, logic [3:0] a, logic [31:0] d,
                     logic ts, logic tf, logic tfr, output logic [31:0] rd);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    tick_slow = ts; tick_fast = tf; tick_free = tfr;
    #1;
    rd = bus_rdata;
    if (!we) check(tag_of(a), {8'd0, bus_rdata}, {8'd0, exp_read(a)});
    check("R6 irq", {37'd0, irq}, {37'd0, m_pend});
    model_step(we, a, d, ts, tf, tfr);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    logic [31:0] r;
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, r);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] r);
    cyc(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, r);
  endtask

  task automatic tick(logic ts, logic tf, logic tfr);
    logic [31:0] r;
    cyc(1'b0, 4'd15, 32'd0, ts, tf, tfr, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int c = 0; c < 3; c++) begin
      m_load[c] = '0; m_cnt[c] = '0; m_ctrl[c] = '0;
    end
    m_pend = '0; m_free = '0; m_fen = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(4'd1, r);  check("R1 count", {8'd0, r}, 40'd0);
    rd(4'd13, r); check("R1 wide", {8'd0, r}, 40'd0);
    check("R1 irq", {37'd0, irq}, 40'd0);

    wr(4'd0, 32'd3);
    rd(4'd1, r);  check("R2 count", {8'd0, r}, 40'd3);
    wr(4'd2, 32'h48);
    rd(4'd2, r);  check("R11 ctrl", {8'd0, r}, 40'h48);
    tick(1'b1, 1'b0, 1'b0); tick(1'b1, 1'b1, 1'b0);
    rd(4'd1, r);  check("R7 hold", {8'd0, r}, 40'd3);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, r);  check("R11 mask", {8'd0, r}, 40'hC8);
    wr(4'd2, 32'hC0);
    tick(1'b0, 1'b1, 1'b0);
    rd(4'd1, r);  check("R3 other tick", {8'd0, r}, 40'd3);
    tick(1'b1, 1'b0, 1'b0);
    rd(4'd1, r);  check("R3 dec", {8'd0, r}, 40'd2);
    tick(1'b1, 1'b0, 1'b0); tick(1'b1, 1'b0, 1'b0);
    check("R4 no irq yet", {37'd0, irq}, 40'd0);
    tick(1'b1, 1'b0, 1'b0);
    rd(4'd1, r);  check("R4 reload", {8'd0, r}, 40'd3);
    check("R6 irq set", {39'd0, irq[0]}, 40'd1);
    wr(4'd3, 32'h1234);
    rd(4'd1, r);  check("R6 cleared", {39'd0, irq[0]}, 40'd0);

    wr(4'd4, 32'h0001_2345);
    rd(4'd4, r);  check("R8 truncate", {8'd0, r}, 40'h2345);
    wr(4'd4, 32'd1); wr(4'd6, 32'h88);
    tick(1'b0, 1'b1, 1'b0); tick(1'b0, 1'b1, 1'b0);
    rd(4'd5, r);  check("R5 wrap16", {8'd0, r}, 40'hFFFF);
    wr(4'd8, 32'd0); wr(4'd10, 32'h80);
    tick(1'b1, 1'b0, 1'b0);
    rd(4'd9, r);  check("R5 wrap32", {8'd0, r}, 40'hFFFF_FFFF);

    wr(4'd2, 32'd0); wr(4'd6, 32'd0); wr(4'd10, 32'd0);
    wr(4'd3, 32'd0); wr(4'd7, 32'd0); wr(4'd11, 32'd0);
    tick(1'b0, 1'b0, 1'b1);
    rd(4'd12, r); check("R9 stopped", {8'd0, r}, 40'd0);
    wr(4'd13, 32'h100);
    for (int k = 0; k < 5; k++) tick(1'b0, 1'b0, 1'b1);
    rd(4'd12, r); check("R9 low", {8'd0, r}, 40'd5);
    rd(4'd13, r); check("R9 high", {8'd0, r}, 40'h100);
    check("R10 no irq", {37'd0, irq}, 40'd0);
    wr(4'd13, 32'h0);
    rd(4'd12, r); check("R9 zeroed", {8'd0, r}, 40'd0);

    wr(4'd0, 32'd0); wr(4'd2, 32'hC0);
    cyc(1'b1, 4'd3, 32'd0, 1'b1, 1'b0, 1'b0, r);
    rd(4'd1, r);  check("R6 set wins", {39'd0, irq[0]}, 40'd1);

    wr(4'd13, 32'h100);
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [3:0] a;
      logic [31:0] d;
      we = ($urandom % 5) == 0;
      a  = 4'($urandom % 16);
      d  = $urandom;
      if (a < 4'd12 && a[1:0] == 2'd0) d = $urandom % 8;
      if (a == 4'd13) d = (($urandom % 4) != 0) ? 32'h100 : 32'h0;
      if (a < 4'd12 && a[1:0] == 2'd2 && ($urandom % 3) != 0) d[7] = 1'b1;
      cyc(we, a, d, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 3) != 0, r);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule